// File: doc/BRIEF.md
# Clock Output Strap Capture and Stop Gating

This block sits between the register file, the board straps and the output stage of a multi-output clock generator. When the power-good input first goes high it samples the strap pins (a frequency-select code and a current-multiplier select bit), keeps those values for the rest of the power cycle, and raises a pin-direction signal so the shared pins can be driven as clock outputs from then on. The kept values are offered to software inverted, and the multiplier bit is offered unchanged to the output stage.

For every clock output the block forms an enable from the output's active bit, the global power-good level and, where that output class obeys them, the two active-low stop inputs. The enable is taken into a per-output gate register only while that output's source clock is low, so a gated clock never produces a shortened high pulse. The gated clock is the source clock ANDed with the gate. A register bit chooses whether the frequency code handed to the synthesiser comes from the straps or from a register.

Outputs are numbered in four consecutive groups: CPU pairs from index 0, then the free-running-capable PCI outputs, then the ordinary PCI outputs, then the remaining outputs (reference, memory, graphics, fixed-rate).

Top module: `clkgen_stop_ctrl`

## Requirements
- R1: During and after reset, before power-good has risen, every gate and gated clock is 0, the pin-direction signal `strap_oe` is 0, `xtal_run` is 0 and `strap_readback` is all ones (the straps are taken as 0 until captured).
- R2: On the first clock edge at which `pwr_good` is high after having been low (or after reset), `strap_pins` are captured; from the next cycle `strap_oe` is 1, `mult_sel` equals the captured bit `strap_pins[FS_W]`, and the captured code occupies bits `[FS_W-1:0]`.
- R3: After capture, later power-good edges and any change of `strap_pins` have no effect on `strap_readback` or `mult_sel`.
- R4: After capture, `pwr_good` low turns every output off (each gate drops at the next edge where its source is low) and drives `xtal_run` to 0; `xtal_run` is 1 only when captured and `pwr_good` is high.
- R5: An output whose `out_active` bit is 0 has its gate cleared; with the bit at 1 and no stop applying, the gate is set.
- R6: `pci_stop_n` low stops every ordinary PCI output; a free-running-capable PCI output k (index N_CPU+k) stops only when `pcif_stop_en[k]` is 1.
- R7: `cpu_stop_n` low stops CPU output k (index k) only when `cpu_stop_en[k]` is 1.
- R8: The remaining outputs ignore both stop inputs.
- R9: A gate register changes value only at an edge where its own source clock is low, so each gated output starts and stops while low.
- R10: `fs_sel` equals `reg_fs` when `fs_from_reg` is 1, and the captured strap code `strap_pins[FS_W-1:0]` when 0.
- R11: `strap_readback` is the bitwise inverse of the captured strap vector.
- R12: `clk_out[i]` equals `src_clk[i]` AND `gate[i]` for every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good level |
| strap_pins | input | FS_W+1 | Strap values: code in [FS_W-1:0], multiplier in [FS_W] |
| cpu_stop_n | input | 1 | Active-low CPU stop |
| pci_stop_n | input | 1 | Active-low PCI stop |
| out_active | input | N_OUT | Per-output active bits |
| cpu_stop_en | input | N_CPU | 1 = CPU output obeys stop |
| pcif_stop_en | input | N_PCIF | 1 = free-running-capable PCI output obeys stop |
| fs_from_reg | input | 1 | 1 = frequency code from register |
| reg_fs | input | FS_W | Register frequency code |
| src_clk | input | N_OUT | Ungated source clocks |
| strap_oe | output | 1 | Shared pins now drive outputs |
| strap_readback | output | FS_W+1 | Inverted captured straps |
| mult_sel | output | 1 | Captured multiplier select |
| fs_sel | output | FS_W | Chosen frequency code |
| xtal_run | output | 1 | Crystal clock enable |
| gate | output | N_OUT | Per-output gate state |
| clk_out | output | N_OUT | Gated clocks |

## Verification
The hardest situation to reach is a stop or enable change landing while a slow source clock is high, where the gate must hold until the source falls; the bench runs the sources at three different rates and flips enables and stops on arbitrary cycles so that both the held and the taken case occur on every output. A second hard case is a second power-good rise with different strap values, which the bench produces by dropping and raising power-good after capture and then comparing the readback with the first capture.

// File: rtl/csc_pkg.sv
package csc_pkg;

   typedef enum logic [1:0] {
      CLS_CPU  = 2'd0,
      CLS_PCIF = 2'd1,
      CLS_PCI  = 2'd2,
      CLS_MISC = 2'd3
   } out_class_e;

   function automatic out_class_e class_of(input int idx, input int n_cpu,
                                           input int n_pcif, input int n_pci);
      if (idx < n_cpu)                 return CLS_CPU;
      if (idx < n_cpu + n_pcif)        return CLS_PCIF;
      if (idx < n_cpu + n_pcif + n_pci) return CLS_PCI;
      return CLS_MISC;
   endfunction

endpackage

// File: rtl/csc_strap_latch.sv
module csc_strap_latch #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pwr_good,
   input  logic [W-1:0] pins,
   output logic         done,
   output logic [W-1:0] value
);

   logic pg_q;
   logic take;

   assign take = pwr_good & ~pg_q & ~done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_q  <= 1'b0;
         done  <= 1'b0;
         value <= '0;
      end else begin
         pg_q <= pwr_good;
         if (take) begin
            done  <= 1'b1;
            value <= pins;
         end
      end
   end

endmodule

// File: rtl/csc_gate_cell.sv
module csc_gate_cell #(
   parameter bit GLITCH_FREE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_clk,
   input  logic want,
   output logic gate,
   output logic clk_out
);

   generate
      if (GLITCH_FREE) begin : g_low_only
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       gate <= 1'b0;
            else if (!src_clk) gate <= want;
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) gate <= 1'b0;
            else        gate <= want;
         end
      end
   endgenerate

   assign clk_out = src_clk & gate;

endmodule

// File: rtl/csc_fs_mux.sv
module csc_fs_mux #(
   parameter int FS_W = 5
) (
   input  logic            from_reg,
   input  logic [FS_W-1:0] reg_code,
   input  logic [FS_W-1:0] strap_code,
   output logic [FS_W-1:0] code
);

   always_comb begin
      code = from_reg ? reg_code : strap_code;
   end

endmodule

// File: rtl/clkgen_stop_ctrl.sv
module clkgen_stop_ctrl #(
   parameter int FS_W        = 5,
   parameter int N_CPU       = 2,
   parameter int N_PCIF      = 2,
   parameter int N_PCI       = 6,
   parameter int N_MISC      = 4,
   parameter bit GLITCH_FREE = 1'b1,
   localparam int STRAP_W    = FS_W + 1,
   localparam int N_OUT      = N_CPU + N_PCIF + N_PCI + N_MISC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwr_good,
   input  logic [STRAP_W-1:0] strap_pins,
   input  logic               cpu_stop_n,
   input  logic               pci_stop_n,
   input  logic [N_OUT-1:0]   out_active,
   input  logic [N_CPU-1:0]   cpu_stop_en,
   input  logic [N_PCIF-1:0]  pcif_stop_en,
   input  logic               fs_from_reg,
   input  logic [FS_W-1:0]    reg_fs,
   input  logic [N_OUT-1:0]   src_clk,
   output logic               strap_oe,
   output logic [STRAP_W-1:0] strap_readback,
   output logic               mult_sel,
   output logic [FS_W-1:0]    fs_sel,
   output logic               xtal_run,
   output logic [N_OUT-1:0]   gate,
   output logic [N_OUT-1:0]   clk_out
);

   import csc_pkg::*;

   generate
      if (FS_W < 1 || FS_W > 16) begin : g_bad_fs
         $error("clkgen_stop_ctrl: FS_W out of range");
      end
      if (N_CPU < 1 || N_PCIF < 1 || N_PCI < 1 || N_MISC < 1) begin : g_bad_cnt
         $error("clkgen_stop_ctrl: every output group needs at least one member");
      end
   endgenerate

   logic               cap_done;
   logic [STRAP_W-1:0] cap_val;
   logic               run_ok;
   logic [N_OUT-1:0]   stop_req;
   logic [N_OUT-1:0]   want;

   csc_strap_latch #(.W(STRAP_W)) i_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_good (pwr_good),
      .pins     (strap_pins),
      .done     (cap_done),
      .value    (cap_val)
   );

   csc_fs_mux #(.FS_W(FS_W)) i_fs_mux (
      .from_reg   (fs_from_reg),
      .reg_code   (reg_fs),
      .strap_code (cap_val[FS_W-1:0]),
      .code       (fs_sel)
   );

   assign strap_oe       = cap_done;
   assign strap_readback = ~cap_val;
   assign mult_sel       = cap_val[FS_W];
   assign run_ok         = cap_done & pwr_good;
   assign xtal_run       = run_ok;

   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      localparam out_class_e CLS = class_of(i, N_CPU, N_PCIF, N_PCI);

      if (CLS == CLS_CPU) begin : g_cpu
         assign stop_req[i] = ~cpu_stop_n & cpu_stop_en[i];
      end else if (CLS == CLS_PCIF) begin : g_pcif
         assign stop_req[i] = ~pci_stop_n & pcif_stop_en[i-N_CPU];
      end else if (CLS == CLS_PCI) begin : g_pci
         assign stop_req[i] = ~pci_stop_n;
      end else begin : g_misc
         assign stop_req[i] = 1'b0;
      end

      assign want[i] = run_ok & out_active[i] & ~stop_req[i];

      csc_gate_cell #(.GLITCH_FREE(GLITCH_FREE)) i_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .src_clk (src_clk[i]),
         .want    (want[i]),
         .gate    (gate[i]),
         .clk_out (clk_out[i])
      );
   end

endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
   parameter int FS_W   = 5,
   parameter int N_CPU  = 2,
   parameter int N_OUT  = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_good,
   input logic             cpu_stop_n,
   input logic [N_CPU-1:0] cpu_stop_en,
   input logic [N_OUT-1:0] src_clk,
   input logic [N_OUT-1:0] gate,
   input logic             strap_oe,
   input logic [FS_W:0]    strap_readback
);

   // R2
   latch_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strap_oe && pwr_good && !$past(pwr_good)) |=> strap_oe);

   // R3
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(strap_oe) |-> $stable(strap_readback));

   for (genvar i = 0; i < N_OUT; i++) begin : g_o
      // R9
      gate_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(gate[i]) |-> !$past(src_clk[i]));
      // R4
      pg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (strap_oe && !pwr_good && !src_clk[i]) |=> !gate[i]);
   end

   for (genvar k = 0; k < N_CPU; k++) begin : g_c
      // R7
      cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!cpu_stop_n && cpu_stop_en[k] && !src_clk[k]) |=> !gate[k]);
   end

endmodule

bind clkgen_stop_ctrl csc_checker #(.FS_W(FS_W), .N_CPU(N_CPU), .N_OUT(N_OUT)) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .pwr_good       (pwr_good),
   .cpu_stop_n     (cpu_stop_n),
   .cpu_stop_en    (cpu_stop_en),
   .src_clk        (src_clk),
   .gate           (gate),
   .strap_oe       (strap_oe),
   .strap_readback (strap_readback)
);

// File: tb/test_clkgen_stop_ctrl.sv
module test_clkgen_stop_ctrl;

   localparam int FS_W = 5, N_CPU = 2, N_PCIF = 2, N_PCI = 6, N_MISC = 4;
   localparam int SW = FS_W + 1;
   localparam int NO = N_CPU + N_PCIF + N_PCI + N_MISC;

   logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b0;
   logic [SW-1:0]    strap_pins = '0;
   logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
   logic [NO-1:0]    out_active = '1;
   logic [N_CPU-1:0] cpu_stop_en = '0;
   logic [N_PCIF-1:0] pcif_stop_en = '0;
   logic fs_from_reg = 1'b0;
   logic [FS_W-1:0] reg_fs = '0;
   logic [NO-1:0]   src_clk = '0;
   logic strap_oe, mult_sel, xtal_run;
   logic [SW-1:0]   strap_readback;
   logic [FS_W-1:0] fs_sel;
   logic [NO-1:0]   gate, clk_out;

   int checks = 0, errors = 0, cyc = 0;
   bit started = 0;

   always #2 clk = ~clk;

   clkgen_stop_ctrl i_clkgen_stop_ctrl (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // reference model
   bit          m_pgq, m_done;
   bit [SW-1:0] m_val;
   bit [NO-1:0] m_gate;

   function automatic bit m_want(input int i);
      bit stop;
      if (!(m_done && pwr_good && out_active[i])) return 0;
      if (i < N_CPU)                      stop = !cpu_stop_n && cpu_stop_en[i];
      else if (i < N_CPU + N_PCIF)        stop = !pci_stop_n && pcif_stop_en[i-N_CPU];
      else if (i < N_CPU + N_PCIF + N_PCI) stop = !pci_stop_n;
      else                                stop = 0;
      return !stop;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pgq <= 0; m_done <= 0; m_val <= '0; m_gate <= '0;
      end else begin
         for (int i = 0; i < NO; i++)
            if (!src_clk[i]) m_gate[i] <= m_want(i);
         if (pwr_good && !m_pgq && !m_done) begin
            m_done <= 1; m_val <= strap_pins;
         end
         m_pgq <= pwr_good;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (started) begin
         chk(gate === m_gate, "R5/R6/R7/R8/R9 gate", 32'(gate), 32'(m_gate));
         chk(clk_out === (src_clk & m_gate), "R12 clk_out", 32'(clk_out), 32'(src_clk & m_gate));
         chk(strap_oe === m_done, "R2 strap_oe", 32'(strap_oe), 32'(m_done));
         chk(strap_readback === ~m_val, "R11 readback", 32'(strap_readback), 32'(~m_val));
         chk(mult_sel === m_val[FS_W], "R2 mult_sel", 32'(mult_sel), 32'(m_val[FS_W]));
         chk(fs_sel === (fs_from_reg ? reg_fs : m_val[FS_W-1:0]), "R10 fs_sel",
             32'(fs_sel), 32'(fs_from_reg ? reg_fs : m_val[FS_W-1:0]));
         chk(xtal_run === (m_done && pwr_good), "R4 xtal_run", 32'(xtal_run), 32'(m_done && pwr_good));
      end
      if (cyc > 100000) begin
         errors++; checks++;
         $display("FAIL watchdog act=%0d exp=<100000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // source clocks at three rates
   int scnt = 0;
   always @(negedge clk) begin
      #1;
      scnt++;
      for (int i = 0; i < NO; i++) src_clk[i] = scnt[i % 3];
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      strap_pins = 6'b101101;
      started = 1;
      step(4);
      // R1 reset state
      chk(gate === '0 && strap_oe === 1'b0 && xtal_run === 1'b0, "R1 reset outputs",
          {gate, strap_oe, xtal_run}, 32'h0);
      chk(strap_readback === 6'h3F, "R1 reset readback", 32'(strap_readback), 32'h3F);
      #1 rst_n = 1;
      step(3);
      chk(strap_oe === 1'b0 && gate === '0, "R1 no capture without power-good", 32'(strap_oe), 0);
      // R2 capture
      #1 pwr_good = 1;
      step(1);
      chk(strap_oe === 1'b1, "R2 strap_oe after edge", 32'(strap_oe), 1);
      chk(strap_readback === 6'b010010, "R2 captured readback", 32'(strap_readback), 32'h12);
      #1 strap_pins = 6'b010011;
      step(12);
      chk(gate === '1, "R5 all active running", 32'(gate), 32'(NO'('1)));
      // R4 power-good low
      #1 pwr_good = 0;
      step(10);
      chk(gate === '0 && xtal_run === 1'b0, "R4 power-good low stops all", 32'(gate), 0);
      #1 pwr_good = 1;
      step(10);
      chk(strap_readback === 6'b010010 && mult_sel === 1'b1, "R3 second rise ignored",
          32'(strap_readback), 32'h12);
      // R5 active bits
      #1 out_active = 14'b10_1100_1010_0110;
      step(10);
      chk(gate === 14'b10_1100_1010_0110, "R5 inactive outputs off", 32'(gate), 32'h2CA6);
      #1 out_active = '1; pcif_stop_en = 2'b01; pci_stop_n = 0;
      step(10);
      // R6: PCI [4..9] off, PCIF index 2 off, index 3 runs, CPU and misc run
      chk(gate === 14'b11_1100_0000_1011, "R6 PCI stop", 32'(gate), 32'h3C0B);
      #1 pci_stop_n = 1; cpu_stop_en = 2'b10; cpu_stop_n = 0;
      step(10);
      chk(gate === 14'b11_1111_1111_1101, "R7 CPU stop per bit", 32'(gate), 32'h3FFD);
      #1 pci_stop_n = 0; cpu_stop_en = '1; pcif_stop_en = '1;
      step(10);
      chk(gate[NO-1 -: N_MISC] === '1, "R8 misc ignore stops", 32'(gate), 32'h3C00);
      #1 cpu_stop_n = 1; pci_stop_n = 1; fs_from_reg = 1; reg_fs = 5'h17;
      step(1);
      chk(fs_sel === 5'h17, "R10 register code", 32'(fs_sel), 32'h17);
      #1 fs_from_reg = 0;
      step(1);
      chk(fs_sel === 5'b01101, "R10 strap code", 32'(fs_sel), 32'h0D);
      // randomised run, model compared every cycle (R9 included)
      for (int n = 0; n < 600; n++) begin
         #1;
         out_active   = NO'($urandom);
         cpu_stop_n   = $urandom_range(0, 1);
         pci_stop_n   = $urandom_range(0, 1);
         cpu_stop_en  = N_CPU'($urandom);
         pcif_stop_en = N_PCIF'($urandom);
         fs_from_reg  = $urandom_range(0, 1);
         reg_fs       = FS_W'($urandom);
         strap_pins   = SW'($urandom);
         pwr_good     = ($urandom_range(0, 9) != 0);
         step($urandom_range(1, 4));
      end
      chk(strap_readback === 6'b010010, "R3 readback after random run", 32'(strap_readback), 32'h12);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule